// File: doc/BRIEF.md
# Fan-in-limited hierarchical prefix network

The block computes every running combination of N operands under one associative operator picked at elaboration: integer addition, bitwise OR or unsigned maximum. Lane i of the result is the fold of operand lanes 0 through i, always taken in lane order. The network is built only from operator nodes that take at most K inputs.

The operands are first cut into a binary hierarchy of aligned groups: halves, quarters, and so on down to single elements. The product of each group is formed by its own K-ary tree. Each prefix then joins the few group products that match the binary digits of its length, using a second K-ary tree.

A word enters on a valid/ready input. With the output register enabled, the result leaves one cycle later on a valid/ready output. A result that is not taken stays held, and the input stalls while it waits. With the register disabled, the path is purely combinational and ready passes straight through.

Top module: `prefix_net`

## Requirements
- R1: With operand lanes packed so that lane j sits at bits [j*W +: W], output lane i equals x0∘x1∘…∘xi, folded strictly in ascending lane order.
- R2: Operator code 0 is addition modulo 2^W, so any carry beyond W bits is dropped.
- R3: Operator code 1 is bitwise OR, so every output lane holds all bits of the lanes below it.
- R4: Operator code 2 is unsigned maximum, so output lanes never decrease with lane index.
- R5: Results do not depend on the fan-in limit K: a network with K=3 and a network with K=4 give the same prefixes for the same operands.
- R6: A synchronous active-high reset clears out_valid and out_data to zero, leaving in_ready high.
- R7: With the register enabled, a word accepted at a rising edge appears on out_data, with out_valid high, right after that same edge. Before that edge, out_valid is still low.
- R8: While out_valid is high and out_ready is low, out_data and out_valid hold. A word offered meanwhile is not taken, and it is taken once out_ready returns.
- R9: in_ready is high exactly when the output register is empty or being drained. A transfer happens only when in_valid and in_ready are both high.
- R10: With the register disabled, out_data is the prefix of the present in_data in the same cycle, out_valid follows in_valid, and in_ready follows out_ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand word offered |
| in_ready | output | 1 | Block can take a word |
| in_data | input | N*W | N packed operands, lane 0 in the low bits |
| out_valid | output | 1 | Prefix word available |
| out_ready | input | 1 | Consumer takes the prefix word |
| out_data | output | N*W | N packed prefixes, lane 0 in the low bits |

## Verification
With the register enabled, a prefix word is due right after the edge that accepts the operands. The bench drives inputs on falling edges and checks registered outputs on the following falling edge, once that single capture edge has passed. The combinational instance is checked one time unit after its inputs change, with no clock edge in between. In the back-pressure scenario, out_valid, in_ready and out_data are sampled on each of the stalled cycles, then the released cycle, then the drained cycle, against the word expected at that point.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_OR  = 2'd1,
    OP_MAX = 2'd2
  } scan_op_e;

  // number of node levels needed to fold m operands with fan-in k
  function automatic int tree_depth(input int m, input int k);
    int c;
    int d;
    c = m;
    d = 0;
    while (c > 1) begin
      c = (c + k - 1) / k;
      d++;
    end
    return d;
  endfunction

  // operand count entering node level d
  function automatic int level_count(input int m, input int k, input int d);
    int c;
    c = m;
    for (int i = 0; i < d; i++) c = (c + k - 1) / k;
    return c;
  endfunction

  // group products joined to form the prefix of length len (1..n)
  function automatic int slot_count(input int len, input int n);
    int c;
    if (len == n) return 2;
    c = 0;
    for (int b = 0; b < 31; b++) if (((len >> b) & 1) == 1) c++;
    return c;
  endfunction

  // group size exponent of slot t, slots ordered from the lowest lanes up
  function automatic int slot_bit(input int len, input int n, input int t, input int lg);
    int seen;
    if (len == n) return lg - 1;
    seen = 0;
    for (int b = lg - 1; b >= 0; b--) begin
      if (((len >> b) & 1) == 1) begin
        if (seen == t) return b;
        seen++;
      end
    end
    return 0;
  endfunction

  // index, within its size class, of the group used by slot t
  function automatic int slot_group(input int len, input int n, input int t, input int lg);
    int b;
    if (len == n) return t;
    b = slot_bit(len, n, t, lg);
    return (len >> (b + 1)) << 1;
  endfunction

endpackage

// File: rtl/scan_kary_tree.sv
// Folds M operands in order with a tree of nodes of at most K inputs.
module scan_kary_tree #(
  parameter int W = 8,
  parameter int K = 4,
  parameter int M = 4,
  parameter scan_pkg::scan_op_e OP = scan_pkg::OP_ADD
) (
  input  logic [M*W-1:0] opnds,
  output logic [W-1:0]   result
);
  localparam int DEPTH = scan_pkg::tree_depth(M, K);

  function automatic logic [W-1:0] join2(input logic [W-1:0] lo, input logic [W-1:0] hi);
    case (OP)
      scan_pkg::OP_OR:  return lo | hi;
      scan_pkg::OP_MAX: return (hi > lo) ? hi : lo;
      default:          return lo + hi;
    endcase
  endfunction

  logic [W-1:0] lv [0:DEPTH][0:M-1];

  genvar j, d, t;
  generate
    for (j = 0; j < M; j++) begin : g_leaf
      assign lv[0][j] = opnds[j*W +: W];
    end

    for (d = 0; d < DEPTH; d++) begin : g_lvl
      localparam int CIN  = scan_pkg::level_count(M, K, d);
      localparam int COUT = (CIN + K - 1) / K;
      for (j = 0; j < M; j++) begin : g_node
        if (j < COUT) begin : g_used
          // one K-input node, operands taken lowest lane first
          logic [W-1:0] ch [0:K-1];
          assign ch[0] = lv[d][j*K];
          for (t = 1; t < K; t++) begin : g_in
            if (j*K + t < CIN) begin : g_take
              assign ch[t] = join2(ch[t-1], lv[d][j*K + t]);
            end else begin : g_skip
              assign ch[t] = ch[t-1];
            end
          end
          assign lv[d+1][j] = ch[K-1];
        end else begin : g_idle
          assign lv[d+1][j] = '0;
        end
      end
    end
  endgenerate

  assign result = lv[DEPTH][0];

  logic unused_tail;
  always_comb begin
    unused_tail = 1'b0;
    for (int a = 0; a <= DEPTH; a++)
      for (int b = 0; b < M; b++)
        unused_tail = unused_tail ^ (^lv[a][b]);
  end
endmodule

// File: rtl/scan_group_stage.sv
// Products of all aligned binary groups of size 2^b, b = 0..LG-1.
// Entry (b, g) sits at gp_flat[(b*N + g)*W +: W].
module scan_group_stage #(
  parameter int N = 16,
  parameter int W = 8,
  parameter int K = 4,
  parameter scan_pkg::scan_op_e OP = scan_pkg::OP_ADD,
  localparam int LG = $clog2(N)
) (
  input  logic [N*W-1:0]    opnds,
  output logic [LG*N*W-1:0] gp_flat
);
  genvar b, g;
  generate
    for (b = 0; b < LG; b++) begin : g_size
      localparam int S   = 1 << b;
      localparam int CNT = N >> b;
      for (g = 0; g < N; g++) begin : g_grp
        if (g < CNT && b == 0) begin : g_single
          assign gp_flat[(b*N + g)*W +: W] = opnds[g*W +: W];
        end else if (g < CNT) begin : g_tree
          scan_kary_tree #(.W(W), .K(K), .M(S), .OP(OP)) u_tree (
            .opnds  (opnds[g*S*W +: S*W]),
            .result (gp_flat[(b*N + g)*W +: W])
          );
        end else begin : g_none
          assign gp_flat[(b*N + g)*W +: W] = '0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/scan_join_stage.sv
// Each prefix joins the group products that match the binary digits of its length.
module scan_join_stage #(
  parameter int N = 16,
  parameter int W = 8,
  parameter int K = 4,
  parameter scan_pkg::scan_op_e OP = scan_pkg::OP_ADD,
  localparam int LG = $clog2(N)
) (
  input  logic [LG*N*W-1:0] gp_flat,
  output logic [N*W-1:0]    prefix
);
  genvar i, t;
  generate
    for (i = 0; i < N; i++) begin : g_lane
      localparam int LEN = i + 1;
      localparam int C   = scan_pkg::slot_count(LEN, N);
      logic [C*W-1:0] pick;
      for (t = 0; t < C; t++) begin : g_slot
        localparam int B = scan_pkg::slot_bit(LEN, N, t, LG);
        localparam int G = scan_pkg::slot_group(LEN, N, t, LG);
        assign pick[t*W +: W] = gp_flat[(B*N + G)*W +: W];
      end
      scan_kary_tree #(.W(W), .K(K), .M(C), .OP(OP)) u_join (
        .opnds  (pick),
        .result (prefix[i*W +: W])
      );
    end
  endgenerate

  logic unused_gp;
  assign unused_gp = ^gp_flat;
endmodule

// File: rtl/prefix_net.sv
module prefix_net #(
  parameter int N = 16,
  parameter int W = 8,
  parameter int K = 4,
  parameter scan_pkg::scan_op_e OP = scan_pkg::OP_ADD,
  parameter bit REG_OUT = 1'b1,
  localparam int LG = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N*W-1:0] in_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [N*W-1:0] out_data
);
  logic [LG*N*W-1:0] gp_flat;
  logic [N*W-1:0]    prefix;

  scan_group_stage #(.N(N), .W(W), .K(K), .OP(OP)) u_groups (
    .opnds   (in_data),
    .gp_flat (gp_flat)
  );

  scan_join_stage #(.N(N), .W(W), .K(K), .OP(OP)) u_join (
    .gp_flat (gp_flat),
    .prefix  (prefix)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic           vld_q;
      logic [N*W-1:0] dat_q;

      assign in_ready  = !vld_q || out_ready;
      assign out_valid = vld_q;
      assign out_data  = dat_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q <= 1'b0;
          dat_q <= '0;
        end else if (in_ready) begin
          vld_q <= in_valid;
          if (in_valid) dat_q <= prefix;
        end
      end

      // R6: reset empties the output stage
      a_r6_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

      // R8: a stalled result holds
      a_r8_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

      // R7: lane 0 of an accepted word shows up one edge later
      a_r7_lane0_next: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_valid && out_data[W-1:0] == $past(in_data[W-1:0])));
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = prefix;
      logic unused_ctl;
      assign unused_ctl = clk ^ rst;
    end
  endgenerate

  genvar i;
  generate
    for (i = 0; i + 1 < N; i++) begin : g_mono
      if (OP == scan_pkg::OP_OR) begin : g_or
        // R3: each lane contains the bits of the lane below
        a_r3_or_grows: assert property (@(posedge clk) disable iff (rst)
          out_valid |-> ((out_data[i*W +: W] & ~out_data[(i+1)*W +: W]) == '0));
      end else if (OP == scan_pkg::OP_MAX) begin : g_max
        // R4: running maximum never falls
        a_r4_max_rises: assert property (@(posedge clk) disable iff (rst)
          out_valid |-> (out_data[i*W +: W] <= out_data[(i+1)*W +: W]));
      end
    end
  endgenerate
endmodule

// File: tb/prefix_net_bench.sv
`timescale 1ns/1ps
module prefix_net_bench;
  localparam int N = 16;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [N*W-1:0] in_data = '0;

  logic add_ir, add_ov, or_ir, or_ov, max_ir, max_ov, cmb_ir, cmb_ov;
  logic [N*W-1:0] add_q, or_q, max_q, cmb_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prefix_net #(.N(N), .W(W), .K(4), .OP(scan_pkg::OP_ADD), .REG_OUT(1'b1)) u_prefix_net (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(add_ir), .in_data(in_data),
    .out_valid(add_ov), .out_ready(out_ready), .out_data(add_q));

  prefix_net #(.N(N), .W(W), .K(2), .OP(scan_pkg::OP_OR), .REG_OUT(1'b1)) u_or_k2 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(or_ir), .in_data(in_data),
    .out_valid(or_ov), .out_ready(out_ready), .out_data(or_q));

  prefix_net #(.N(N), .W(W), .K(8), .OP(scan_pkg::OP_MAX), .REG_OUT(1'b1)) u_max_k8 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(max_ir), .in_data(in_data),
    .out_valid(max_ov), .out_ready(out_ready), .out_data(max_q));

  prefix_net #(.N(N), .W(W), .K(3), .OP(scan_pkg::OP_ADD), .REG_OUT(1'b0)) u_add_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(cmb_ir), .in_data(in_data),
    .out_valid(cmb_ov), .out_ready(out_ready), .out_data(cmb_q));

  // running fold, lane by lane: 0 add, 1 or, 2 unsigned max
  function automatic logic [N*W-1:0] ref_scan(input int op, input logic [N*W-1:0] v);
    logic [W-1:0] acc;
    logic [W-1:0] x;
    ref_scan = '0;
    acc = '0;
    for (int j = 0; j < N; j++) begin
      x = v[j*W +: W];
      if (j == 0) acc = x;
      else if (op == 0) acc = acc + x;
      else if (op == 1) acc = acc | x;
      else if (x > acc) acc = x;
      ref_scan[j*W +: W] = acc;
    end
  endfunction

  task automatic chk(input string req, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // present one word, check the combinational instance, capture, check registered ones
  task automatic push_word(input logic [N*W-1:0] v, input string req);
    @(negedge clk);
    in_data = v;
    in_valid = 1'b1;
    out_ready = 1'b1;
    #1;
    chk({req, " R10 comb"}, cmb_q, ref_scan(0, v));
    chk("R10 comb valid", {{(N*W-1){1'b0}}, cmb_ov}, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R1 R2 add"}, add_q, ref_scan(0, v));
    chk({req, " R3 or"}, or_q, ref_scan(1, v));
    chk({req, " R4 max"}, max_q, ref_scan(2, v));
  endtask

  function automatic logic [N*W-1:0] rand_word();
    logic [N*W-1:0] v;
    for (int j = 0; j < N; j++) v[j*W +: W] = W'($urandom);
    return v;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 out_valid", {{(N*W-1){1'b0}}, add_ov}, 0);
    chk("R6 out_data", add_q, '0);
    chk("R6 in_ready", {{(N*W-1){1'b0}}, add_ir}, 1);
    rst = 1'b0;
  endtask

  task automatic t_patterns();
    logic [N*W-1:0] v;
    push_word('0, "zeros");
    for (int j = 0; j < N; j++) v[j*W +: W] = W'(j + 1);
    push_word(v, "ramp");
    for (int r = 0; r < 6; r++) push_word(rand_word(), "random");
  endtask

  task automatic t_wrap();
    push_word({N*W{1'b1}}, "R2 all ones wrap");
  endtask

  task automatic t_or_onehot();
    logic [N*W-1:0] v;
    for (int j = 0; j < N; j++) v[j*W +: W] = W'(1 << (j % W));
    push_word(v, "R3 walking bit");
  endtask

  task automatic t_max_orders();
    logic [N*W-1:0] v;
    for (int j = 0; j < N; j++) v[j*W +: W] = W'(200 - 9*j);
    push_word(v, "R4 descending");
    for (int j = 0; j < N; j++) v[j*W +: W] = (j == N-1) ? 8'hFF : W'(j);
    push_word(v, "R4 peak last");
  endtask

  task automatic t_fanin();
    logic [N*W-1:0] v;
    v = rand_word();
    push_word(v, "R5 fan-in");
    in_data = v;
    #1;
    chk("R5 K3 vs K4", cmb_q, add_q);
  endtask

  task automatic t_latency();
    logic [N*W-1:0] v;
    v = rand_word();
    @(negedge clk);
    chk("R7 idle", {{(N*W-1){1'b0}}, add_ov}, 0);
    in_data = v;
    in_valid = 1'b1;
    #1;
    chk("R7 not yet", {{(N*W-1){1'b0}}, add_ov}, 0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 valid after edge", {{(N*W-1){1'b0}}, add_ov}, 1);
    chk("R7 data after edge", add_q, ref_scan(0, v));
  endtask

  task automatic t_backpressure();
    logic [N*W-1:0] a;
    logic [N*W-1:0] b;
    a = rand_word();
    b = rand_word();
    @(negedge clk);
    in_data = a; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_data = b; out_ready = 1'b0;
    #1;
    chk("R9 ready low when full", {{(N*W-1){1'b0}}, add_ir}, 0);
    @(negedge clk);
    chk("R8 valid held", {{(N*W-1){1'b0}}, add_ov}, 1);
    chk("R8 data held", add_q, ref_scan(0, a));
    out_ready = 1'b1;
    #1;
    chk("R9 ready when draining", {{(N*W-1){1'b0}}, add_ir}, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 offered word taken", add_q, ref_scan(0, b));
    chk("R8 or path", or_q, ref_scan(1, b));
    @(negedge clk);
    chk("R9 empties", {{(N*W-1){1'b0}}, add_ov}, 0);
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_wrap();
    t_or_onehot();
    t_max_orders();
    t_fanin();
    t_latency();
    t_backpressure();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule